// File: doc/BRIEF.md
# Scan Chain Fault Locator

This block watches the parallel outputs of a set of scan chains, one slice (one bit per chain) per scan shift. It runs in one of two modes. In detection mode every slice is folded into a signature register with polynomial feedback. When the last slice of a response arrives, the signature is compared with a supplied expected signature and a pass or fail verdict is raised.

After a failing pattern has been found, the test is re-applied in diagnosis mode. Each slice is then latched and processed over NCODE internal cycles. On each cycle one fixed code word masks the slice, and the XOR of the masked bits is shifted into the same register with feedback turned off. The collected syndrome is XORed with an expected syndrome that is captured along with the slice. Because code column i holds the binary value i+1, a nonzero result points straight at the failing chain. A value outside the column range is reported as a multiple fault.

The internal cycles stand for a collection clock that runs NCODE times faster than the scan clock. The scan source must therefore present at most one slice every NCODE+1 cycles in diagnosis mode.

Top module: `scan_fault_locator`

## Requirements
- R1: After reset, busy_o, det_done_o, det_fail_o, diag_done_o, diag_fault_o and diag_multi_o are 0, and sig_o is all zeros.
- R2: In detection mode each accepted slice d updates the signature s to ((s << 1) XOR (POLY if s[NCHAIN-1] was 1) XOR d), where POLY defaults to 8'h1D. All chain bits enter unmasked. The edge that takes the last slice of a response (resp_last_i high) clears sig_o to zero.
- R3: One cycle after the edge that takes a last slice, det_done_o is high for exactly one cycle. At the same time det_fail_o shows whether the signature including that slice differs from ref_sig_i. A single flipped bit on any chain in any slice of the response makes det_fail_o 1.
- R4: In diagnosis mode, an accepted slice is latched and the register is cleared. During the following NCODE edges, with no feedback, the register shifts in one bit per edge. Bit j, shifted on local cycle j, is the XOR over chains i of slice bit i AND bit j of the value i+1. After collection, syndrome bit j sits at sig_o[NCODE-1-j]. The code words are identical for every pattern.
- R5: diag_done_o rises NCODE edges after the capturing edge and stays high for one cycle only. busy_o is high from the capturing edge until diag_done_o rises.
- R6: With diff = syndrome XOR the expected syndrome: diff = 0 gives diag_fault_o = 0. If 1 <= diff <= NCHAIN, the result is diag_fault_o = 1, diag_multi_o = 0 and diag_chain_o = diff-1. If diff > NCHAIN, diag_fault_o = 1 and diag_multi_o = 1.
- R7: With failures on several chains, diff is the XOR of their column values. Chains 0 and 1 therefore alias to a report of chain 2, while chains 0 and 7 give diff 9 and raise diag_multi_o.
- R8: While busy_o is high, slice_vld_i, slice_i and ref_syn_i are ignored. The expected syndrome is the one present at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| diag_mode_i | input | 1 | 0 = detection, 1 = diagnosis |
| slice_vld_i | input | 1 | A slice is presented this cycle |
| resp_last_i | input | 1 | Slice is the last of a response (detection) |
| slice_i | input | NCHAIN | One output bit from every scan chain |
| ref_sig_i | input | NCHAIN | Expected signature, used with the last slice |
| ref_syn_i | input | NCODE | Expected syndrome for the slice being diagnosed |
| busy_o | output | 1 | Syndrome collection in progress |
| det_done_o | output | 1 | Detection verdict valid (one cycle) |
| det_fail_o | output | 1 | Signature mismatch |
| diag_done_o | output | 1 | Diagnosis result valid (one cycle) |
| diag_fault_o | output | 1 | Nonzero syndrome difference |
| diag_multi_o | output | 1 | Difference matches no single column |
| diag_chain_o | output | $clog2(NCHAIN) | Index of the failing chain |
| sig_o | output | NCHAIN | Signature / syndrome register contents |

## Verification
On every cycle, the assertions check four things. During collection the register moves as a pure shift with no feedback. A last slice leaves the register cleared. Each completion pulse lasts one cycle and follows a busy period. A multiple-fault report always comes with the fault flag. Only the bench scenarios can show the numerical results: the signature values, the pass/fail verdict for a flipped bit, the location of each single faulty chain, the aliasing of double faults, and the fact that slices arriving mid-collection are ignored.

// File: rtl/dg_pkg.sv
package dg_pkg;

   typedef enum logic {
      PH_IDLE    = 1'b0,
      PH_COLLECT = 1'b1
   } dg_phase_e;

   // number of code words needed so that every chain has a distinct nonzero column
   function automatic int code_bits_needed(input int nchain);
      return $clog2(nchain + 1);
   endfunction

endpackage

// File: rtl/dg_code_rom.sv
module dg_code_rom #(
   parameter int NCHAIN = 8,
   parameter int NCODE  = 4
) (
   output logic [NCODE-1:0][NCHAIN-1:0] words_o
);

   // word j, column i = bit j of (i+1)
   for (genvar j = 0; j < NCODE; j++) begin : g_word
      for (genvar i = 0; i < NCHAIN; i++) begin : g_col
         localparam int COLVAL = i + 1;
         assign words_o[j][i] = COLVAL[j];
      end
   end

endmodule

// File: rtl/dg_sig_reg.sv
module dg_sig_reg #(
   parameter int              W    = 8,
   parameter logic [W-1:0]    POLY = W'('h1D)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         misr_en_i,
   input  logic         misr_last_i,
   input  logic         shift_en_i,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] sig_o,
   output logic [W-1:0] next_sig_o
);

   logic [W-1:0] sig_q;
   logic [W-1:0] gated;
   logic         par;

   assign gated      = src_i & mask_i;
   assign par        = ^gated;
   assign next_sig_o = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0) ^ gated;
   assign sig_o      = sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sig_q <= '0;
      else if (clr_i)                      sig_q <= '0;
      else if (misr_en_i && misr_last_i)   sig_q <= '0;
      else if (misr_en_i)                  sig_q <= next_sig_o;
      else if (shift_en_i)                 sig_q <= {sig_q[W-2:0], par};
   end

   // R4: collection is a plain shift, no feedback term
   assert_shift_nofb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en_i && !clr_i && !misr_en_i) |=> (sig_o[W-1:1] == $past(sig_o[W-2:0])));

   // R2: end of response leaves the register empty
   assert_last_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (misr_en_i && misr_last_i && !clr_i) |=> (sig_o == '0));

endmodule

// File: rtl/dg_syn_decode.sv
module dg_syn_decode #(
   parameter int NCHAIN = 8,
   parameter int NCODE  = 4,
   parameter int CW     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCODE-1:0] syn_i,
   input  logic [NCODE-1:0] ref_i,
   output logic             fault_o,
   output logic             multi_o,
   output logic [CW-1:0]    chain_o
);

   localparam logic [NCODE:0] NMAX = (NCODE+1)'(NCHAIN);

   logic [NCODE-1:0] diff;
   logic [NCODE-1:0] idx;

   assign diff    = syn_i ^ ref_i;
   assign fault_o = |diff;
   assign multi_o = ({1'b0, diff} > NMAX);
   assign idx     = diff - NCODE'(1);
   assign chain_o = (fault_o && !multi_o) ? idx[CW-1:0] : '0;

   // R6: a multiple-fault report is always a fault
   assert_multi_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      multi_o |-> fault_o);

endmodule

// File: rtl/scan_fault_locator.sv
module scan_fault_locator
   import dg_pkg::*;
#(
   parameter int                NCHAIN = 8,
   parameter int                NCODE  = 4,
   parameter logic [NCHAIN-1:0] POLY   = NCHAIN'('h1D),
   localparam int               CW     = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
   localparam int               CNTW   = (NCODE > 1) ? $clog2(NCODE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              diag_mode_i,
   input  logic              slice_vld_i,
   input  logic              resp_last_i,
   input  logic [NCHAIN-1:0] slice_i,
   input  logic [NCHAIN-1:0] ref_sig_i,
   input  logic [NCODE-1:0]  ref_syn_i,
   output logic              busy_o,
   output logic              det_done_o,
   output logic              det_fail_o,
   output logic              diag_done_o,
   output logic              diag_fault_o,
   output logic              diag_multi_o,
   output logic [CW-1:0]     diag_chain_o,
   output logic [NCHAIN-1:0] sig_o
);

   if (NCODE < code_bits_needed(NCHAIN)) begin : g_chk_code
      $error("NCODE too small for NCHAIN distinct columns");
   end
   if (NCHAIN < NCODE || NCHAIN < 2) begin : g_chk_width
      $error("signature register narrower than syndrome");
   end
   if (NCODE < CW) begin : g_chk_idx
      $error("NCODE narrower than chain index");
   end

   dg_phase_e         phase_q;
   logic [CNTW-1:0]   cnt_q;
   logic [NCHAIN-1:0] slice_q;
   logic [NCODE-1:0]  ref_q;
   logic              ddone_q, det_done_q, det_fail_q;
   logic              busy, start, det_step, last_local;

   logic [NCODE-1:0][NCHAIN-1:0] words;
   logic [NCHAIN-1:0] mask, src, next_sig;
   logic [NCODE-1:0]  syn;

   assign busy       = (phase_q == PH_COLLECT);
   assign start      = slice_vld_i & diag_mode_i & ~busy;
   assign det_step   = slice_vld_i & ~diag_mode_i & ~busy;
   assign last_local = busy && (cnt_q == CNTW'(NCODE-1));

   dg_code_rom #(.NCHAIN(NCHAIN), .NCODE(NCODE)) u_rom (.words_o(words));

   // detection: all mask bits at one; collection: current code word
   assign mask = busy ? words[cnt_q] : '1;
   assign src  = busy ? slice_q : slice_i;

   dg_sig_reg #(.W(NCHAIN), .POLY(POLY)) u_sig (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start),
      .misr_en_i  (det_step),
      .misr_last_i(resp_last_i),
      .shift_en_i (busy),
      .src_i      (src),
      .mask_i     (mask),
      .sig_o      (sig_o),
      .next_sig_o (next_sig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         cnt_q      <= '0;
         slice_q    <= '0;
         ref_q      <= '0;
         ddone_q    <= 1'b0;
         det_done_q <= 1'b0;
         det_fail_q <= 1'b0;
      end else begin
         ddone_q    <= last_local;
         det_done_q <= det_step & resp_last_i;
         det_fail_q <= det_step & resp_last_i & (next_sig != ref_sig_i);
         if (start) begin
            phase_q <= PH_COLLECT;
            cnt_q   <= '0;
            slice_q <= slice_i;
            ref_q   <= ref_syn_i;
         end else if (last_local) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
         end else if (busy) begin
            cnt_q   <= cnt_q + CNTW'(1);
         end
      end
   end

   // first collected bit ends up highest: reverse into syndrome order
   for (genvar j = 0; j < NCODE; j++) begin : g_rev
      assign syn[j] = sig_o[NCODE-1-j];
   end

   dg_syn_decode #(.NCHAIN(NCHAIN), .NCODE(NCODE), .CW(CW)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .syn_i  (syn),
      .ref_i  (ref_q),
      .fault_o(diag_fault_o),
      .multi_o(diag_multi_o),
      .chain_o(diag_chain_o)
   );

   assign busy_o      = busy;
   assign diag_done_o = ddone_q;
   assign det_done_o  = det_done_q;
   assign det_fail_o  = det_fail_q;

   // R5: completion pulse is one cycle wide
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      diag_done_o |=> !diag_done_o);

   // R5: completion only ends a busy period
   assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(diag_done_o) |-> ($past(busy_o) && !busy_o));

endmodule

// File: tb/sim_scan_fault_locator.sv
module sim_scan_fault_locator;

   localparam int N  = 8;
   localparam int K  = 4;
   localparam int CW = 3;
   localparam logic [N-1:0] POLY = 8'h1D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          diag_mode = 1'b0, vld = 1'b0, last = 1'b0;
   logic [N-1:0]  slice = '0, ref_sig = '0;
   logic [K-1:0]  ref_syn = '0;
   logic          busy, det_done, det_fail, diag_done, diag_fault, diag_multi;
   logic [CW-1:0] diag_chain;
   logic [N-1:0]  sig;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   scan_fault_locator #(.NCHAIN(N), .NCODE(K), .POLY(POLY)) u0 (
      .clk(clk), .rst_n(rst_n), .diag_mode_i(diag_mode), .slice_vld_i(vld),
      .resp_last_i(last), .slice_i(slice), .ref_sig_i(ref_sig), .ref_syn_i(ref_syn),
      .busy_o(busy), .det_done_o(det_done), .det_fail_o(det_fail),
      .diag_done_o(diag_done), .diag_fault_o(diag_fault), .diag_multi_o(diag_multi),
      .diag_chain_o(diag_chain), .sig_o(sig)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] misr(input logic [N-1:0] s, input logic [N-1:0] d);
      return {s[N-2:0], 1'b0} ^ (s[N-1] ? POLY : '0) ^ d;
   endfunction

   function automatic logic [K-1:0] syn_of(input logic [N-1:0] d);
      logic [K-1:0] s = '0;
      for (int i = 0; i < N; i++) if (d[i]) s ^= K'(i + 1);
      return s;
   endfunction

   function automatic logic [K-1:0] rev(input logic [K-1:0] v);
      logic [K-1:0] r;
      for (int j = 0; j < K; j++) r[j] = v[K-1-j];
      return r;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk(busy == 0 && det_done == 0 && det_fail == 0, "R1", "busy/det flags", {busy, det_done, det_fail}, 0);
      chk(diag_done == 0 && diag_fault == 0 && diag_multi == 0, "R1", "diag flags",
          {diag_done, diag_fault, diag_multi}, 0);
      chk(sig == 0, "R1", "sig_o", sig, 0);
   endtask

   // three-slice response; expected signature from the R2 formula
   task automatic t_detect(input logic [N-1:0] a, b, c, input logic [N-1:0] refv,
                           input bit exp_fail, input string tag);
      logic [N-1:0] s;
      diag_mode = 0;
      vld = 1; last = 0; slice = a; ref_sig = refv;
      @(negedge clk);
      s = misr('0, a);
      chk(sig == s, "R2", {tag, " sig after slice 0"}, sig, s);
      slice = b;
      @(negedge clk);
      s = misr(s, b);
      chk(sig == s, "R2", {tag, " sig after slice 1"}, sig, s);
      slice = c; last = 1;
      @(negedge clk);
      vld = 0; last = 0;
      chk(det_done == 1, "R3", {tag, " det_done"}, det_done, 1);
      chk(det_fail == exp_fail, "R3", {tag, " det_fail"}, det_fail, exp_fail);
      chk(sig == 0, "R2", {tag, " cleared after last"}, sig, 0);
      @(negedge clk);
      chk(det_done == 0, "R3", {tag, " det_done one cycle"}, det_done, 0);
   endtask

   task automatic t_detection();
      logic [N-1:0] a = 8'h5A, b = 8'hC3, c = 8'h91;
      logic [N-1:0] good = misr(misr(misr('0, a), b), c);
      t_detect(a, b, c, good, 1'b0, "pass");
      t_detect(a, b ^ 8'h20, c, good, 1'b1, "flip chain5");
      t_detect(a, b, c ^ 8'h01, good, 1'b1, "flip chain0");
      t_detect(a, b, c, good, 1'b0, "pass again");
   endtask

   task automatic t_diag(input logic [N-1:0] d, input logic [K-1:0] refv, input bit disturb,
                         input bit ef, input bit em, input int ec, input string tag);
      int  seen_t = 0, pulses = 0;
      bit  f = 0, m = 0;
      int  ch = 0;
      logic [K-1:0] low = '0;
      diag_mode = 1; vld = 1; slice = d; ref_syn = refv;
      @(negedge clk);
      vld = 0;
      chk(busy == 1, "R5", {tag, " busy after capture"}, busy, 1);
      if (disturb) begin
         vld = 1; slice = ~d; ref_syn = ~refv;
      end
      for (int t = 2; t <= K + 3; t++) begin
         @(negedge clk);
         vld = 0;
         if (diag_done) begin
            pulses++;
            if (seen_t == 0) begin
               seen_t = t; f = diag_fault; m = diag_multi; ch = int'(diag_chain);
               low = sig[K-1:0];
            end
         end
      end
      chk(seen_t == K + 1, "R5", {tag, " done cycle"}, seen_t, K + 1);
      chk(pulses == 1, "R5", {tag, " done pulses"}, pulses, 1);
      chk(low == rev(syn_of(d)), "R4", {tag, " syndrome bits"}, low, rev(syn_of(d)));
      chk(f == ef, "R6", {tag, " fault"}, f, ef);
      chk(m == em, "R6", {tag, " multi"}, m, em);
      if (ef && !em) chk(ch == ec, "R6", {tag, " chain"}, ch, ec);
      diag_mode = 0;
   endtask

   task automatic t_single_faults();
      logic [N-1:0] g = 8'hA6;
      for (int c = 0; c < N; c++)
         t_diag(g ^ N'(1 << c), syn_of(g), 1'b0, 1'b1, 1'b0, c, $sformatf("single chain %0d", c));
      t_diag(g, syn_of(g), 1'b0, 1'b0, 1'b0, 0, "no fault");
   endtask

   task automatic t_multi_faults();
      logic [N-1:0] g = 8'h3C;
      t_diag(g ^ 8'h03, syn_of(g), 1'b0, 1'b1, 1'b0, 2, "R7 chains 0+1 alias");
      t_diag(g ^ 8'h81, syn_of(g), 1'b0, 1'b1, 1'b1, 0, "R7 chains 0+7 multi");
      t_diag(g ^ 8'h24, syn_of(g), 1'b0, 1'b1, 1'b0, 4, "R7 chains 2+5 alias");
   endtask

   task automatic t_busy_ignore();
      logic [N-1:0] g = 8'h6E;
      t_diag(g ^ 8'h40, syn_of(g), 1'b1, 1'b1, 1'b0, 6, "R8 disturbed");
      t_diag(g ^ 8'h40, syn_of(g), 1'b0, 1'b1, 1'b0, 6, "R8 same code again");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_detection();
      t_single_faults();
      t_multi_faults();
      t_busy_ignore();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule